// File: doc/BRIEF.md
# Endpoint Buffer Allocation Checker

This block sits beside the endpoint configuration registers of a USB device controller. All endpoints share one packet buffer memory. Each configuration write names one endpoint and carries its size code, direction, transfer type, bank count and transactions-per-microframe count. The block decides whether that configuration is legal. It keeps one mapped flag per endpoint and a running total of the buffer bytes that the mapped endpoints claim.

Each write is judged in one clock cycle. Any demand the endpoint already holds is released first. The new demand is then checked against the type rules and against the capacity left over. A bus reset keeps the default control endpoint (index 0) and drops every other endpoint. The block does not assign buffer base addresses, and it does not contain the buffer RAM or the protocol engine.

Top module: `ep_alloc_check`

## Requirements
- R1: After rst_n is released, every mapped bit is 0, every dir_in bit is 0, and used_bytes is 0.
- R2: A legal write sets mapped[cfg_ep] in the next cycle. Size code c (0..7) selects 8<<c bytes. The endpoint's demand is bytes × cfg_banks, and that demand is added to used_bytes.
- R3: A write is accepted only if the total after the write is at most BUF_BYTES (4096). A total of exactly 4096 is accepted. A rejected write clears mapped[cfg_ep], and used_bytes then holds no demand for that endpoint.
- R4: A bank count of 0, or of more than MAX_BANKS (3), is rejected.
- R5: A control endpoint (type 0) must use exactly 1 bank. Its direction bit has no effect on legality or on demand, and its dir_in bit reads 0.
- R6: Size code 7 (1024 bytes) is accepted only for an isochronous endpoint (type 1).
- R7: Endpoint 0 accepts only the control type. Endpoints 1 and up accept isochronous (1), bulk (2) or interrupt (3), and reject the control type.
- R8: An isochronous endpoint needs a transactions count of 1 to 3, so 0 is rejected. For all other types the transactions count is ignored.
- R9: Reconfiguring an endpoint releases its previous demand before the new demand is checked against capacity.
- R10: A write with cfg_enable low disables the endpoint. It clears mapped[cfg_ep] and releases that endpoint's demand.
- R11: A bus_reset pulse clears mapped and dir_in for every endpoint except endpoint 0, and sets used_bytes to endpoint 0's demand. A write in the same cycle as the bus_reset pulse has no effect.
- R12: For a mapped endpoint that is not a control endpoint, dir_in holds the direction bit of the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | One-cycle pulse marking the end of a bus reset |
| cfg_valid | input | 1 | A configuration write is present this cycle |
| cfg_ep | input | EPW (3) | Index of the endpoint being written |
| cfg_enable | input | 1 | 1 = activate the endpoint, 0 = disable it |
| cfg_size | input | 3 | Size code; the size is 8 << code bytes |
| cfg_dir | input | 1 | Direction, 1 = IN |
| cfg_type | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| cfg_banks | input | BW (2) | Number of banks |
| cfg_trans | input | 2 | Transactions per microframe (isochronous only) |
| mapped | output | NUM_EP (8) | Per-endpoint flag: the configuration is legal and holds buffer space |
| dir_in | output | NUM_EP (8) | Stored direction bit of each mapped endpoint |
| used_bytes | output | UW (13) | Buffer bytes claimed by all mapped endpoints |

## Verification
The bound checker evaluates these rules on every cycle:
- used_bytes never exceeds the buffer size.
- Nothing changes when no write or bus reset arrives.
- A zero bank count, a non-isochronous 1024-byte size, a disable, or a control type on a nonzero endpoint always leaves the flag clear.
- A bus reset always leaves only endpoint 0 mapped.

Some behaviours need a history of writes, so only the bench's scenarios can show them:
- the exact byte total after a sequence of writes;
- release-before-check on reconfiguration;
- acceptance at exactly 4096 bytes and rejection just above it;
- the transactions-count rule.

// File: rtl/ep_alloc_check.sv
module ep_alloc_check #(
  parameter int NUM_EP    = 8,
  parameter int BUF_BYTES = 4096,
  parameter int MAX_BANKS = 3,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int BW  = $clog2(MAX_BANKS + 1),
  localparam int UW  = $clog2(BUF_BYTES + 1),
  localparam int DW  = $clog2(1024 * MAX_BANKS + 1),
  localparam int CW  = UW + DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              cfg_valid,
  input  logic [EPW-1:0]    cfg_ep,
  input  logic              cfg_enable,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_dir,
  input  logic [1:0]        cfg_type,
  input  logic [BW-1:0]     cfg_banks,
  input  logic [1:0]        cfg_trans,
  output logic [NUM_EP-1:0] mapped,
  output logic [NUM_EP-1:0] dir_in,
  output logic [UW-1:0]     used_bytes
);

  localparam logic [1:0] T_CTRL = 2'd0;
  localparam logic [1:0] T_ISO  = 2'd1;

  logic [DW-1:0] demand_q [NUM_EP];

  logic          is_ctrl, is_iso;
  logic          type_ok, bank_ok, size_ok, trans_ok, fits, legal;
  logic [10:0]   ep_bytes;
  logic [DW-1:0] new_dem, old_dem;
  logic [CW-1:0] base, total;

  assign is_ctrl  = (cfg_type == T_CTRL);
  assign is_iso   = (cfg_type == T_ISO);
  assign type_ok  = (cfg_ep == '0) ? is_ctrl : !is_ctrl;
  assign bank_ok  = (cfg_banks != '0) && (int'(cfg_banks) <= MAX_BANKS) &&
                    (!is_ctrl || cfg_banks == BW'(1));
  assign size_ok  = (cfg_size != 3'd7) || is_iso;
  assign trans_ok = !is_iso || (cfg_trans != 2'd0);

  assign ep_bytes = 11'd8 << cfg_size;
  assign new_dem  = DW'(ep_bytes) * DW'(cfg_banks);
  assign old_dem  = demand_q[cfg_ep];
  assign base     = CW'(used_bytes) - CW'(old_dem);
  assign total    = base + CW'(new_dem);
  assign fits     = (total <= CW'(BUF_BYTES));
  assign legal    = cfg_enable && type_ok && bank_ok && size_ok && trans_ok && fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapped     <= '0;
      dir_in     <= '0;
      used_bytes <= '0;
      for (int i = 0; i < NUM_EP; i++) demand_q[i] <= '0;
    end else if (bus_reset) begin
      for (int i = 1; i < NUM_EP; i++) begin
        mapped[i]   <= 1'b0;
        dir_in[i]   <= 1'b0;
        demand_q[i] <= '0;
      end
      used_bytes <= UW'(demand_q[0]);
    end else if (cfg_valid) begin
      mapped[cfg_ep]   <= legal;
      dir_in[cfg_ep]   <= legal && !is_ctrl && cfg_dir;
      demand_q[cfg_ep] <= legal ? new_dem : '0;
      used_bytes       <= legal ? UW'(total) : UW'(base);
    end
  end

endmodule

module ep_alloc_check_sva #(
  parameter int NUM_EP    = 8,
  parameter int BUF_BYTES = 4096,
  parameter int MAX_BANKS = 3,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int BW  = $clog2(MAX_BANKS + 1),
  localparam int UW  = $clog2(BUF_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              cfg_valid,
  input logic [EPW-1:0]    cfg_ep,
  input logic              cfg_enable,
  input logic [2:0]        cfg_size,
  input logic [1:0]        cfg_type,
  input logic [BW-1:0]     cfg_banks,
  input logic [NUM_EP-1:0] mapped,
  input logic [NUM_EP-1:0] dir_in,
  input logic [UW-1:0]     used_bytes
);

  assert_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_bytes) <= BUF_BYTES);

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid && !bus_reset |=> $stable(mapped) && $stable(used_bytes) && $stable(dir_in));

  assert_zero_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !bus_reset && cfg_banks == '0 |=> !mapped[$past(cfg_ep)]);

  assert_big_non_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !bus_reset && cfg_size == 3'd7 && cfg_type != 2'd1 |=> !mapped[$past(cfg_ep)]);

  assert_ctrl_high_ep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !bus_reset && cfg_ep != '0 && cfg_type == 2'd0 |=> !mapped[$past(cfg_ep)]);

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !bus_reset && !cfg_enable |=> !mapped[$past(cfg_ep)] && !dir_in[$past(cfg_ep)]);

  assert_bus_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (mapped >> 1) == '0 && (dir_in >> 1) == '0 && $stable(mapped[0]));

endmodule

bind ep_alloc_check ep_alloc_check_sva #(
  .NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES), .MAX_BANKS(MAX_BANKS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cfg_valid(cfg_valid),
  .cfg_ep(cfg_ep), .cfg_enable(cfg_enable), .cfg_size(cfg_size),
  .cfg_type(cfg_type), .cfg_banks(cfg_banks), .mapped(mapped),
  .dir_in(dir_in), .used_bytes(used_bytes)
);

// File: tb/ep_alloc_check_tb.sv
module ep_alloc_check_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [2:0] cfg_ep = '0;
  logic       cfg_enable = 1'b0;
  logic [2:0] cfg_size = '0;
  logic       cfg_dir = 1'b0;
  logic [1:0] cfg_type = '0;
  logic [1:0] cfg_banks = '0;
  logic [1:0] cfg_trans = '0;
  logic [7:0] mapped;
  logic [7:0] dir_in;
  logic [12:0] used_bytes;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [1:0] CTRL = 2'd0, ISO = 2'd1, BULK = 2'd2, INTR = 2'd3;

  always #2 clk = ~clk;

  ep_alloc_check u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cfg_valid(cfg_valid),
    .cfg_ep(cfg_ep), .cfg_enable(cfg_enable), .cfg_size(cfg_size),
    .cfg_dir(cfg_dir), .cfg_type(cfg_type), .cfg_banks(cfg_banks),
    .cfg_trans(cfg_trans), .mapped(mapped), .dir_in(dir_in),
    .used_bytes(used_bytes)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ep, bit en, int sz, bit dir, logic [1:0] ty, int bk, int tr);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_ep = 3'(ep); cfg_enable = en; cfg_size = 3'(sz);
    cfg_dir = dir; cfg_type = ty; cfg_banks = 2'(bk); cfg_trans = 2'(tr);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mapped", int'(mapped), 0);
    check("R1 dir_in", int'(dir_in), 0);
    check("R1 used", int'(used_bytes), 0);
  endtask

  task automatic t_basic;
    wr(0, 1, 3, 0, CTRL, 1, 0);
    check("R2 ep0 mapped", int'(mapped[0]), 1);
    check("R2 used 64", int'(used_bytes), 64);
    wr(1, 1, 6, 1, BULK, 2, 0);
    check("R2 ep1 mapped", int'(mapped[1]), 1);
    check("R2 used 1088", int'(used_bytes), 1088);
    check("R12 ep1 dir", int'(dir_in[1]), 1);
  endtask

  task automatic t_control;
    wr(0, 1, 3, 0, CTRL, 2, 0);
    check("R5 two banks rejected", int'(mapped[0]), 0);
    check("R5 used after reject", int'(used_bytes), 1024);
    wr(0, 1, 3, 1, CTRL, 1, 0);
    check("R5 dir ignored mapped", int'(mapped[0]), 1);
    check("R5 dir ignored used", int'(used_bytes), 1088);
    check("R5 ctrl dir_in zero", int'(dir_in[0]), 0);
  endtask

  task automatic t_types;
    wr(2, 1, 3, 0, CTRL, 1, 0);
    check("R7 ctrl on ep2", int'(mapped[2]), 0);
    check("R7 used unchanged", int'(used_bytes), 1088);
    wr(0, 1, 3, 0, BULK, 1, 0);
    check("R7 bulk on ep0", int'(mapped[0]), 0);
    check("R7 ep0 released", int'(used_bytes), 1024);
    wr(0, 1, 3, 0, CTRL, 1, 0);
    check("R7 ep0 restored", int'(used_bytes), 1088);
  endtask

  task automatic t_big;
    wr(2, 1, 7, 0, BULK, 1, 0);
    check("R6 1024 bulk", int'(mapped[2]), 0);
    check("R6 used unchanged", int'(used_bytes), 1088);
    wr(2, 1, 7, 0, ISO, 1, 1);
    check("R6 1024 iso", int'(mapped[2]), 1);
    check("R6 used 2112", int'(used_bytes), 2112);
  endtask

  task automatic t_trans;
    wr(3, 1, 3, 0, ISO, 1, 0);
    check("R8 iso trans0", int'(mapped[3]), 0);
    wr(3, 1, 3, 0, ISO, 1, 2);
    check("R8 iso trans2", int'(mapped[3]), 1);
    wr(4, 1, 3, 0, INTR, 1, 0);
    check("R8 intr trans ignored", int'(mapped[4]), 1);
    check("R8 used 2240", int'(used_bytes), 2240);
  endtask

  task automatic t_banks;
    wr(5, 1, 0, 0, BULK, 0, 0);
    check("R4 zero banks", int'(mapped[5]), 0);
    check("R4 used unchanged", int'(used_bytes), 2240);
  endtask

  task automatic t_budget;
    wr(5, 1, 6, 0, BULK, 3, 0);
    check("R3 ep5 fits", int'(used_bytes), 3776);
    wr(6, 1, 5, 0, BULK, 2, 0);
    check("R3 over rejected", int'(mapped[6]), 0);
    check("R3 used unchanged", int'(used_bytes), 3776);
    wr(6, 1, 5, 0, BULK, 1, 0);
    check("R3 ep6 fits", int'(used_bytes), 4032);
    wr(7, 1, 3, 0, BULK, 1, 0);
    check("R3 exact 4096", int'(mapped[7]), 1);
    check("R3 used 4096", int'(used_bytes), 4096);
    wr(7, 1, 4, 0, BULK, 1, 0);
    check("R3 4160 rejected", int'(mapped[7]), 0);
    check("R3 used after release", int'(used_bytes), 4032);
  endtask

  task automatic t_reconfig;
    wr(5, 1, 6, 1, BULK, 3, 0);
    check("R9 reconfig accepted", int'(mapped[5]), 1);
    check("R9 used same", int'(used_bytes), 4032);
  endtask

  task automatic t_disable;
    wr(6, 0, 5, 0, BULK, 1, 0);
    check("R10 ep6 off", int'(mapped[6]), 0);
    check("R10 used 3776", int'(used_bytes), 3776);
  endtask

  task automatic t_bus_reset;
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    check("R11 only ep0", int'(mapped), 1);
    check("R11 used ep0", int'(used_bytes), 64);
    check("R11 dir cleared", int'(dir_in), 0);
    @(negedge clk);
    bus_reset = 1'b1;
    cfg_valid = 1'b1; cfg_ep = 3'd1; cfg_enable = 1'b1; cfg_size = 3'd3;
    cfg_dir = 1'b0; cfg_type = BULK; cfg_banks = 2'd1; cfg_trans = 2'd0;
    @(negedge clk);
    bus_reset = 1'b0; cfg_valid = 1'b0;
    check("R11 write ignored", int'(mapped), 1);
    check("R11 used held", int'(used_bytes), 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_control();
    t_types();
    t_big();
    t_trans();
    t_banks();
    t_budget();
    t_reconfig();
    t_disable();
    t_bus_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule